// File: doc/BRIEF.md
# Disk Field Write Formatter

The formatter turns one sector field into the 16-bit word stream that a disk write channel serializes. After a start pulse it sends a zero preamble so the read side can lock its clock, then one word that marks the word boundary, then the caller's payload words, then a CRC-16 check word. After that it keeps write-enable asserted for a short tail so the check word fully drains through the drive's delayed write gate. Then it freezes and reports completion. One clock cycle carries one word.

The boundary word depends on the drive class. One class takes an all-ones sync word. The other takes an address mark, with a tag bit set when the field is a label or data field rather than a header. The same engine also produces a compare stream for verify passes. In that mode write-enable never rises and the tail is not lengthened. Payload arrives over a ready/valid handshake. A missing payload word during a payload slot aborts the field and raises a sticky underrun flag.

Top module: `dfw_formatter`

## Requirements
- R1: While reset is asserted and after it, before any start, busy_o, done_o, wr_en_o, word_valid_o, pay_ready_o and underrun_o are all 0.
- R2: A start accepted while idle is followed, from the next cycle, by exactly 6 cycles that each carry a valid zero word. During a write pass wr_en_o is 1 from the first preamble cycle through the tail.
- R3: With drive_b_i=0 latched at start, the word after the preamble is 0xFFFF.
- R4: With drive_b_i=1 latched at start, the word after the preamble is 0x50A1 when field_type_i bit 7 is 0 (header, 0x40) and 0x50A3 when it is 1 (label 0x80, data 0xC0).
- R5: For a word count N>0, pay_ready_o is high for exactly the payload slots that follow the marker. Each payload word is emitted in the cycle it is accepted, in order, until N words have been taken.
- R6: The cycle after the last payload word carries the CRC word. This is CRC-16 with polynomial 0x1021 and preset 0xFFFF, fed MSB first over the marker and all payload words, with no final inversion.
- R7: After the CRC word, wr_en_o stays high with word_valid_o low for 1 cycle on drive_b_i=0 and for 2 cycles on a drive_b_i=1 write.
- R8: With verify_i=1 latched at start, wr_en_o stays 0 for the whole field and the tail lasts 1 cycle whatever the drive class.
- R9: busy_o is high from the cycle after an accepted start through the freeze cycle. done_o is high for that single freeze cycle, and busy_o is low after it.
- R10: A start pulse while busy_o is high has no effect on the running field's words, timing or configuration.
- R11: If pay_valid_i is low during a payload slot, underrun_o is set from the next cycle and the field is aborted. The next cycle is the freeze cycle, with no CRC word and no tail. underrun_o stays set until the next accepted start clears it.
- R12: With word count 0, the CRC word directly follows the marker and covers the marker alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one word time per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a field (taken only when idle) |
| field_type_i | input | 8 | Field code: 0x40 header, 0x80 label, 0xC0 data |
| drive_b_i | input | 1 | 1 selects address-mark drive class, 0 selects sync-word class |
| verify_i | input | 1 | 1 produces a compare stream with write-enable held low |
| word_cnt_i | input | CNT_W | Number of payload words |
| pay_data_i | input | 16 | Payload word |
| pay_valid_i | input | 1 | Payload word present |
| pay_ready_o | output | 1 | Payload slot open |
| word_o | output | 16 | Outgoing word |
| word_valid_o | output | 1 | word_o carries a field word this cycle |
| wr_en_o | output | 1 | Write gate to the drive |
| busy_o | output | 1 | Field in progress |
| done_o | output | 1 | Single-cycle freeze indication |
| underrun_o | output | 1 | Sticky payload underrun |

## Verification
A wrong sequencer state or count shows at the ports in the same cycle, as a shifted preamble length, a missing or extra payload slot, or a tail of the wrong length on wr_en_o. The reference model compares every output on every cycle, so such errors are caught at the first bad word. A corrupted CRC register shows only in the single CRC cycle of each field. Feeding fields with different marker values, lengths and a zero-length field places that cycle under several distinct residues. A stuck underrun flag is exposed in the idle cycles after an aborted field and again at the next start.

// File: rtl/dfw_pkg.sv
`timescale 1ns/1ps
package dfw_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_MARK, ST_PAY, ST_CRC, ST_TAIL, ST_FRZ
  } fmt_state_e;

  typedef struct packed {
    logic drive_b;
    logic verify;
    logic lab_dat;
  } fmt_cfg_t;
endpackage

// File: rtl/dfw_crc16.sv
`timescale 1ns/1ps
module dfw_crc16 #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  // whole word folded MSB first in one cycle
  always_comb begin
    crc_d = crc_q;
    fb    = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      fb    = crc_d[W-1] ^ data_i[i];
      crc_d = {crc_d[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (init_i) crc_q <= INIT;
    else if (en_i)   crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/dfw_marker.sv
`timescale 1ns/1ps
module dfw_marker #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SYNC_WORD  = 16'hFFFF,
  parameter logic [W-1:0] AMARK_WORD = 16'h50A1,
  parameter logic [W-1:0] TAG_MASK   = 16'h0002
) (
  input  logic         drive_b_i,
  input  logic         lab_dat_i,
  output logic [W-1:0] mark_o
);
  assign mark_o = drive_b_i ? (AMARK_WORD | (lab_dat_i ? TAG_MASK : '0)) : SYNC_WORD;
endmodule

// File: rtl/dfw_ctrl.sv
`timescale 1ns/1ps
module dfw_ctrl
  import dfw_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PRE_WORDS  = 6,
  parameter int unsigned TAIL_BASE  = 1,
  parameter int unsigned TAIL_EXTRA = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             drive_b_i,
  input  logic             verify_i,
  input  logic             lab_dat_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic             pay_valid_i,
  output fmt_state_e       state_o,
  output fmt_cfg_t         cfg_o,
  output logic             accept_o,
  output logic             underrun_o
);
  localparam int unsigned PRE_W = $clog2(PRE_WORDS + 1);
  localparam int unsigned TL_W  = $clog2(TAIL_BASE + TAIL_EXTRA + 1);
  localparam int unsigned AW    = (CNT_W > PRE_W) ? CNT_W : PRE_W;
  localparam int unsigned CW    = (AW > TL_W) ? AW : TL_W;

  fmt_state_e       state_q, state_d;
  fmt_cfg_t         cfg_q, cfg_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             under_q, under_d;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    under_d = under_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cfg_d   = '{drive_b: drive_b_i, verify: verify_i, lab_dat: lab_dat_i};
        len_d   = word_cnt_i;
        cnt_d   = CW'(PRE_WORDS - 1);
        under_d = 1'b0;
        state_d = ST_PRE;
      end
      ST_PRE: begin
        if (cnt_q == '0) state_d = ST_MARK;
        else             cnt_d = cnt_q - CW'(1);
      end
      ST_MARK: begin
        if (len_q == '0) state_d = ST_CRC;
        else begin
          cnt_d   = CW'(len_q) - CW'(1);
          state_d = ST_PAY;
        end
      end
      ST_PAY: begin
        if (!pay_valid_i) begin
          under_d = 1'b1;
          state_d = ST_FRZ;
        end else if (cnt_q == '0) state_d = ST_CRC;
        else cnt_d = cnt_q - CW'(1);
      end
      ST_CRC: begin
        cnt_d   = (cfg_q.drive_b && !cfg_q.verify) ? CW'(TAIL_BASE + TAIL_EXTRA - 1)
                                                  : CW'(TAIL_BASE - 1);
        state_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (cnt_q == '0) state_d = ST_FRZ;
        else             cnt_d = cnt_q - CW'(1);
      end
      ST_FRZ:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      under_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      under_q <= under_d;
    end
  end

  assign state_o    = state_q;
  assign cfg_o      = cfg_q;
  assign accept_o   = accept;
  assign underrun_o = under_q;
endmodule

// File: rtl/dfw_formatter.sv
`timescale 1ns/1ps
module dfw_formatter
  import dfw_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned PRE_WORDS    = 6,
  parameter int unsigned TAIL_BASE    = 1,
  parameter int unsigned TAIL_EXTRA   = 1,
  parameter int unsigned TYPE_TAG_BIT = 7,
  parameter logic [15:0] SYNC_WORD    = 16'hFFFF,
  parameter logic [15:0] AMARK_WORD   = 16'h50A1,
  parameter logic [15:0] TAG_MASK     = 16'h0002
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       field_type_i,
  input  logic             drive_b_i,
  input  logic             verify_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [15:0]      pay_data_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  output logic [15:0]      word_o,
  output logic             word_valid_o,
  output logic             wr_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);
  fmt_state_e        state;
  fmt_cfg_t          cfg;
  logic              accept;
  logic [WORD_W-1:0] mark_word, crc_word, out_word;
  logic              crc_en;

  dfw_ctrl #(
    .CNT_W(CNT_W), .PRE_WORDS(PRE_WORDS),
    .TAIL_BASE(TAIL_BASE), .TAIL_EXTRA(TAIL_EXTRA)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .drive_b_i(drive_b_i), .verify_i(verify_i),
    .lab_dat_i(field_type_i[TYPE_TAG_BIT]), .word_cnt_i(word_cnt_i),
    .pay_valid_i(pay_valid_i), .state_o(state), .cfg_o(cfg),
    .accept_o(accept), .underrun_o(underrun_o)
  );

  dfw_marker #(
    .W(WORD_W), .SYNC_WORD(SYNC_WORD), .AMARK_WORD(AMARK_WORD), .TAG_MASK(TAG_MASK)
  ) u_marker (
    .drive_b_i(cfg.drive_b), .lab_dat_i(cfg.lab_dat), .mark_o(mark_word)
  );

  always_comb begin
    unique case (state)
      ST_MARK: out_word = mark_word;
      ST_PAY:  out_word = pay_data_i;
      ST_CRC:  out_word = crc_word;
      default: out_word = '0;
    endcase
  end

  assign crc_en = (state == ST_MARK) || ((state == ST_PAY) && pay_valid_i);

  dfw_crc16 #(.W(WORD_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(accept), .en_i(crc_en),
    .data_i(out_word), .crc_o(crc_word)
  );

  assign word_o       = out_word;
  assign word_valid_o = (state == ST_PRE) || (state == ST_MARK) || (state == ST_CRC) ||
                        ((state == ST_PAY) && pay_valid_i);
  assign wr_en_o      = !cfg.verify && (state inside {ST_PRE, ST_MARK, ST_PAY, ST_CRC, ST_TAIL});
  assign pay_ready_o  = (state == ST_PAY);
  assign busy_o       = (state != ST_IDLE);
  assign done_o       = (state == ST_FRZ);
endmodule

// File: rtl/dfw_formatter_chk.sv
`timescale 1ns/1ps
module dfw_formatter_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] word_cnt_i,
  input logic             pay_valid_i,
  input logic             pay_ready_o,
  input logic             word_valid_o,
  input logic             wr_en_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             underrun_o
);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r2_valid_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> busy_o);
  a_r7_wr_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (busy_o && !done_o));
  a_r5_ready_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> (busy_o && !done_o));
  a_r10_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !done_o) |=> busy_o);
  a_r11_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_ready_o && !pay_valid_i) |=> (done_o && underrun_o));
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !(start_i && !busy_o)) |=> underrun_o);
  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !underrun_o));
endmodule

bind dfw_formatter dfw_formatter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_cnt_i(word_cnt_i),
  .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o), .word_valid_o(word_valid_o),
  .wr_en_o(wr_en_o), .busy_o(busy_o), .done_o(done_o), .underrun_o(underrun_o)
);

// File: tb/dfw_formatter_bench.sv
`timescale 1ns/1ps
module dfw_formatter_bench;
  localparam int PH_IDLE = 0, PH_PRE = 1, PH_MARK = 2, PH_PAY = 3,
                 PH_CRC = 4, PH_TAIL = 5, PH_FRZ = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ftype = 8'h40;
  logic        drive_b = 1'b0;
  logic        verify = 1'b0;
  logic [7:0]  wcnt = 8'd0;
  logic [15:0] pay_data = 16'h0;
  logic        pay_valid = 1'b0;
  logic        pay_ready, word_valid, wr_en, busy, done, underrun;
  logic [15:0] word;

  always #2.5 clk = ~clk;

  dfw_formatter u_dfw_formatter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .field_type_i(ftype),
    .drive_b_i(drive_b), .verify_i(verify), .word_cnt_i(wcnt),
    .pay_data_i(pay_data), .pay_valid_i(pay_valid), .pay_ready_o(pay_ready),
    .word_o(word), .word_valid_o(word_valid), .wr_en_o(wr_en),
    .busy_o(busy), .done_o(done), .underrun_o(underrun)
  );

  int checks = 0, errors = 0, wd = 0;
  int m_ph = PH_IDLE, m_cnt = 0, m_len = 0, m_idx = 0;
  bit m_b = 0, m_v = 0, m_tag = 0, m_under = 0, in_reset = 1;
  logic [15:0] m_crc = 16'hFFFF;
  logic [15:0] seed = 16'h1D0F;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [15:0] d);
    for (int i = 15; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else              c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [15:0] marker();
    return m_b ? (16'h50A1 | (m_tag ? 16'h0002 : 16'h0000)) : 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(bit st, logic [7:0] ft, bit db, bit vf, int n, bit pv);
    bit e_valid, e_wr;
    logic [15:0] e_word;
    string tg, wtg, vtg;
    @(negedge clk);
    start = st; ftype = ft; drive_b = db; verify = vf; wcnt = n[7:0];
    pay_valid = pv; seed = seed + 16'h3A71; pay_data = seed ^ 16'hC35A;
    #1;
    tg = in_reset ? "R1" : ((st && m_ph != PH_IDLE) ? "R10" : "R9");
    e_valid = (m_ph == PH_PRE) || (m_ph == PH_MARK) || (m_ph == PH_CRC) || (m_ph == PH_PAY && pv);
    e_wr = !m_v && (m_ph >= PH_PRE) && (m_ph <= PH_TAIL);
    wtg = m_v ? "R8" : ((m_ph == PH_TAIL) ? "R7" : (in_reset ? "R1" : "R2"));
    chk(busy == (m_ph != PH_IDLE), tg, "busy", 16'(busy), 16'(m_ph != PH_IDLE));
    chk(done == (m_ph == PH_FRZ), tg, "done", 16'(done), 16'(m_ph == PH_FRZ));
    chk(wr_en == e_wr, wtg, "wr_en", 16'(wr_en), 16'(e_wr));
    vtg = (m_ph == PH_TAIL) ? "R7" : (in_reset ? "R1" : "R5");
    chk(word_valid == e_valid, vtg, "valid", 16'(word_valid), 16'(e_valid));
    chk(pay_ready == (m_ph == PH_PAY), in_reset ? "R1" : "R5", "ready",
        16'(pay_ready), 16'(m_ph == PH_PAY));
    chk(underrun == m_under, in_reset ? "R1" : "R11", "underrun", 16'(underrun), 16'(m_under));
    if (e_valid) begin
      case (m_ph)
        PH_PRE:  begin e_word = 16'h0;    tg = "R2"; end
        PH_MARK: begin e_word = marker(); tg = m_b ? "R4" : "R3"; end
        PH_PAY:  begin e_word = pay_data; tg = "R5"; end
        default: begin e_word = m_crc;    tg = (m_len == 0) ? "R12" : "R6"; end
      endcase
      chk(word == e_word, tg, "word", word, e_word);
    end
    if (!rst_n) begin
      m_ph = PH_IDLE; m_under = 0;
    end else begin
      case (m_ph)
        PH_IDLE: if (st) begin
          m_b = db; m_v = vf; m_tag = ft[7]; m_len = n; m_cnt = 6;
          m_crc = 16'hFFFF; m_under = 0; m_ph = PH_PRE;
        end
        PH_PRE: begin m_cnt--; if (m_cnt == 0) m_ph = PH_MARK; end
        PH_MARK: begin
          m_crc = crc_step(m_crc, marker()); m_idx = 0;
          m_ph = (m_len == 0) ? PH_CRC : PH_PAY;
        end
        PH_PAY: begin
          if (!pv) begin m_under = 1; m_ph = PH_FRZ; end
          else begin
            m_crc = crc_step(m_crc, pay_data); m_idx++;
            if (m_idx == m_len) m_ph = PH_CRC;
          end
        end
        PH_CRC: begin m_cnt = (m_b && !m_v) ? 2 : 1; m_ph = PH_TAIL; end
        PH_TAIL: begin m_cnt--; if (m_cnt == 0) m_ph = PH_FRZ; end
        default: m_ph = PH_IDLE;
      endcase
    end
  endtask

  task automatic run_field(logic [7:0] ft, bit db, bit vf, int n, int stall_at, int glitch_at);
    int k = 0;
    step(1, ft, db, vf, n, 1);
    while (m_ph != PH_IDLE) begin
      bit gl = (k == glitch_at);
      bit pv = !(m_ph == PH_PAY && m_idx == stall_at);
      step(gl, gl ? 8'h40 : ft, gl ? !db : db, gl ? !vf : vf, gl ? n + 3 : n, pv);
      k++;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      errors++;
      $display("FAIL R9 watchdog actual %0d expected %0d", wd, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(0, 8'h40, 0, 0, 0, 0);  // R1 under reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) step(0, 8'h40, 0, 0, 0, 0);  // R1 after reset
    in_reset = 0;
    run_field(8'h40, 0, 0, 3, -1, -1);  // R3 sync word class
    run_field(8'h40, 1, 0, 2, -1, -1);  // R4 header mark, R7 long tail
    run_field(8'hC0, 1, 0, 4, -1, 5);   // R4 data mark, R10 start while busy
    run_field(8'h80, 1, 1, 2, -1, -1);  // R8 verify
    run_field(8'h80, 0, 0, 0, -1, -1);  // R12 zero length
    run_field(8'hC0, 1, 0, 4, 2, -1);   // R11 underrun abort
    for (int i = 0; i < 3; i++) step(0, 8'h40, 0, 0, 0, 1);  // R11 sticky
    run_field(8'h80, 1, 0, 1, -1, -1);  // R11 cleared by start
    step(0, 8'h40, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule